// File: doc/BRIEF.md
# Partitioned Sign-Magnitude Multiplier

This block multiplies two signed two's-complement operands and returns the full-width signed product. Each operand is first turned into an unsigned magnitude, with its sign bit kept aside. The magnitudes are cut into equal sub-words. Every pairing of an A sub-word with a B sub-word goes to its own small unsigned multiplier. The partial products of equal weight are added together first, and these diagonal sums are then shifted into place and accumulated. The product sign is the XOR of the two operand signs, and the magnitude is negated when that sign is set.

A parameter picks the partitioning. With two parts per operand there are four half-width units, and with four parts there are sixteen quarter-width units. A second parameter selects a data-dependent mode. In that mode, a unit whose operand sub-word is zero has its inputs isolated to zero, so it does not toggle and adds nothing to the sum. The operands are registered when the input strobe is high, and the product is registered one edge later. A result therefore leaves the block two clock edges after its operands are taken in, and one operand pair can be accepted every cycle.

Top module: `psm_mult`

## Requirements
- R1: When `out_valid` is high, `out_prod` equals the signed product of the operands accepted two edges earlier, in 2*WIDTH-bit two's complement, for every operand pair.
- R2: `out_valid` is high at the second rising edge after an edge that sampled `in_valid` high, and low otherwise. Back-to-back strobes give one result per cycle.
- R3: The most negative operand value (-2^(WIDTH-1)) gives a magnitude of 2^(WIDTH-1). For example, (-32768)·(-32768) = 1073741824 and (-32768)·1 = -32768 at WIDTH=16.
- R4: When either operand is zero, every bit of the product is zero, whatever the other operand's sign.
- R5: While `out_valid` is low, `out_prod` keeps its last value. Operands presented with `in_valid` low have no effect on it.
- R6: PARTS=2 builds the product from four (WIDTH/2)-bit units and PARTS=4 from sixteen (WIDTH/4)-bit units. Both give identical results.
- R7: With MODE=PP_GATED, a unit whose A or B sub-word is zero is disabled and contributes exactly zero. Results are bit-identical to MODE=PP_ALL.
- R8: While `rst_n` is low, and after it is released until the first result, `out_valid` is low and `out_prod` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| in_a | input | WIDTH | Signed operand A |
| in_b | input | WIDTH | Signed operand B |
| out_valid | output | 1 | Product strobe, two edges after `in_valid` |
| out_prod | output | 2*WIDTH | Signed product |

## Verification
A wrong sub-word slice, shift weight or diagonal grouping corrupts `out_prod` on the very result that uses the faulty unit. Sweeping every operand pair at a small width therefore exposes it on the second edge after those operands enter.

A sign-handling fault shows up on the first negative or zero-product result. A broken gate shows up as a mismatch between the gated and ungated instances fed the same stream. A misplaced valid register shows up on the first strobe as an early or late `out_valid`, and idle gaps in the stream reveal a product register that loads without a strobe.

// File: rtl/psm_pkg.sv
package psm_pkg;
    typedef enum logic {
        PP_ALL   = 1'b0,
        PP_GATED = 1'b1
    } pp_mode_e;
endpackage

// File: rtl/psm_magnitude.sv
module psm_magnitude #(
    parameter int W = 16
) (
    input  logic [W-1:0] value,
    output logic [W-1:0] mag,
    output logic         neg
);
    assign neg = value[W-1];
    assign mag = neg ? (~value + W'(1)) : value;
endmodule

// File: rtl/psm_sub_mult.sv
module psm_sub_mult #(
    parameter int               SW   = 8,
    parameter psm_pkg::pp_mode_e MODE = psm_pkg::PP_ALL
) (
    input  logic [SW-1:0]   op_a,
    input  logic [SW-1:0]   op_b,
    output logic            en,
    output logic [2*SW-1:0] pp
);
    logic [SW-1:0] a_iso;
    logic [SW-1:0] b_iso;

    generate
        if (MODE == psm_pkg::PP_GATED) begin : g_gate
            assign en = (|op_a) & (|op_b);
        end else begin : g_free
            assign en = 1'b1;
        end
    endgenerate

    assign a_iso = en ? op_a : '0;
    assign b_iso = en ? op_b : '0;
    assign pp    = (2*SW)'(a_iso) * (2*SW)'(b_iso);
endmodule

// File: rtl/psm_combiner.sv
module psm_combiner #(
    parameter int P  = 2,
    parameter int SW = 8
) (
    input  logic [P*P*2*SW-1:0] pp_flat,
    output logic [2*P*SW-1:0]   sum
);
    localparam int W2    = 2 * P * SW;
    localparam int NDIAG = 2 * P - 1;

    logic [W2-1:0] diag [NDIAG];

    always_comb begin
        for (int k = 0; k < NDIAG; k++) begin
            diag[k] = '0;
        end
        for (int i = 0; i < P; i++) begin
            for (int j = 0; j < P; j++) begin
                diag[i+j] = diag[i+j] + W2'(pp_flat[(i*P+j)*2*SW +: 2*SW]);
            end
        end
        sum = '0;
        for (int k = 0; k < NDIAG; k++) begin
            sum = sum + (diag[k] << (k*SW));
        end
    end
endmodule

// File: rtl/psm_mult.sv
module psm_mult #(
    parameter int                WIDTH = 16,
    parameter int                PARTS = 2,
    parameter psm_pkg::pp_mode_e MODE  = psm_pkg::PP_ALL
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [WIDTH-1:0]   in_a,
    input  logic [WIDTH-1:0]   in_b,
    output logic               out_valid,
    output logic [2*WIDTH-1:0] out_prod
);
    localparam int SW    = WIDTH / PARTS;
    localparam int NUNIT = PARTS * PARTS;
    localparam int PW    = 2 * SW;

    logic [WIDTH-1:0]    a_q, b_q;
    logic                v_q;
    logic [WIDTH-1:0]    a_mag, b_mag;
    logic                a_neg, b_neg;
    logic [NUNIT*PW-1:0] pp_flat;
    logic [NUNIT-1:0]    unit_en;
    logic [2*WIDTH-1:0]  mag_prod;
    logic [2*WIDTH-1:0]  signed_prod;
    logic                prod_neg;

    // operand register stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
            v_q <= 1'b0;
        end else begin
            v_q <= in_valid;
            if (in_valid) begin
                a_q <= in_a;
                b_q <= in_b;
            end
        end
    end

    psm_magnitude #(.W(WIDTH)) u_mag_a (.value(a_q), .mag(a_mag), .neg(a_neg));
    psm_magnitude #(.W(WIDTH)) u_mag_b (.value(b_q), .mag(b_mag), .neg(b_neg));

    generate
        for (genvar gi = 0; gi < PARTS; gi++) begin : g_row
            for (genvar gj = 0; gj < PARTS; gj++) begin : g_col
                localparam int IDX = gi * PARTS + gj;
                psm_sub_mult #(.SW(SW), .MODE(MODE)) u_unit (
                    .op_a (a_mag[gi*SW +: SW]),
                    .op_b (b_mag[gj*SW +: SW]),
                    .en   (unit_en[IDX]),
                    .pp   (pp_flat[IDX*PW +: PW])
                );
                AST_GATED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                    !unit_en[IDX] |-> (pp_flat[IDX*PW +: PW] == '0)); // R7
            end
        end
    endgenerate

    psm_combiner #(.P(PARTS), .SW(SW)) u_comb (
        .pp_flat (pp_flat),
        .sum     (mag_prod)
    );

    assign prod_neg    = (a_neg ^ b_neg) && (mag_prod != '0);
    assign signed_prod = prod_neg ? (~mag_prod + (2*WIDTH)'(1)) : mag_prod;

    // product register stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_prod  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= v_q;
            if (v_q) begin
                out_prod <= signed_prod;
            end
        end
    end

    AST_PRODUCT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($signed(out_prod) ==
                       $signed($past(in_a, 2)) * $signed($past(in_b, 2)))); // R1
    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid); // R2
    AST_VALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid); // R2
    AST_ZERO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (($past(in_a, 2) == '0) || ($past(in_b, 2) == '0)))
        |-> (out_prod == '0)); // R4
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_prod)); // R5
endmodule

// File: tb/test_psm_mult.sv
module test_psm_mult;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    // narrow stream: four configurations
    logic        v8 = 1'b0;
    logic [7:0]  a8 = '0, b8 = '0;
    logic [3:0]  ov8;
    logic [15:0] op8 [4];

    // wide stream: two configurations
    logic        v16 = 1'b0;
    logic [15:0] a16 = '0, b16 = '0;
    logic [1:0]  ov16;
    logic [31:0] op16 [2];

    psm_mult #(.WIDTH(16), .PARTS(2), .MODE(psm_pkg::PP_GATED)) i_psm_mult (
        .clk(clk), .rst_n(rst_n), .in_valid(v16), .in_a(a16), .in_b(b16),
        .out_valid(ov16[0]), .out_prod(op16[0]));
    psm_mult #(.WIDTH(16), .PARTS(4), .MODE(psm_pkg::PP_ALL)) i_psm_mult_w16p4 (
        .clk(clk), .rst_n(rst_n), .in_valid(v16), .in_a(a16), .in_b(b16),
        .out_valid(ov16[1]), .out_prod(op16[1]));
    psm_mult #(.WIDTH(8), .PARTS(2), .MODE(psm_pkg::PP_ALL)) i_psm_mult_w8p2a (
        .clk(clk), .rst_n(rst_n), .in_valid(v8), .in_a(a8), .in_b(b8),
        .out_valid(ov8[0]), .out_prod(op8[0]));
    psm_mult #(.WIDTH(8), .PARTS(2), .MODE(psm_pkg::PP_GATED)) i_psm_mult_w8p2g (
        .clk(clk), .rst_n(rst_n), .in_valid(v8), .in_a(a8), .in_b(b8),
        .out_valid(ov8[1]), .out_prod(op8[1]));
    psm_mult #(.WIDTH(8), .PARTS(4), .MODE(psm_pkg::PP_ALL)) i_psm_mult_w8p4a (
        .clk(clk), .rst_n(rst_n), .in_valid(v8), .in_a(a8), .in_b(b8),
        .out_valid(ov8[2]), .out_prod(op8[2]));
    psm_mult #(.WIDTH(8), .PARTS(4), .MODE(psm_pkg::PP_GATED)) i_psm_mult_w8p4g (
        .clk(clk), .rst_n(rst_n), .in_valid(v8), .in_a(a8), .in_b(b8),
        .out_valid(ov8[3]), .out_prod(op8[3]));

    bit          pv8 [2];
    logic [15:0] pe8 [2];
    logic [15:0] held8 = '0;
    bit          pv16 [2];
    logic [31:0] pe16 [2];
    logic [31:0] held16 = '0;

    task automatic chk(input string req, input int inst, input logic [31:0] got,
                       input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s inst %0d: got %h expected %h", req, inst, got, exp);
        end
    endtask

    task automatic cyc8(input bit v, input logic [7:0] a, input logic [7:0] b,
                        input string tag);
        @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            chk("R2", k, 32'(ov8[k]), 32'(pv8[1]));
            if (pv8[1]) chk(tag, k, 32'(op8[k]), 32'(pe8[1]));
            else        chk("R5", k, 32'(op8[k]), 32'(held8));
        end
        if (pv8[1]) held8 = pe8[1];
        pv8[1] = pv8[0];
        pe8[1] = pe8[0];
        pv8[0] = v;
        pe8[0] = 16'($signed({{8{a[7]}}, a}) * $signed({{8{b[7]}}, b}));
        v8 = v;
        a8 = a;
        b8 = b;
    endtask

    task automatic cyc16(input bit v, input logic [15:0] a, input logic [15:0] b,
                         input string tag);
        @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            chk("R2", 10 + k, 32'(ov16[k]), 32'(pv16[1]));
            if (pv16[1]) chk(tag, 10 + k, op16[k], pe16[1]);
            else         chk("R5", 10 + k, op16[k], held16);
        end
        if (pv16[1]) held16 = pe16[1];
        pv16[1] = pv16[0];
        pe16[1] = pe16[0];
        pv16[0] = v;
        pe16[0] = 32'($signed({{16{a[15]}}, a}) * $signed({{16{b[15]}}, b}));
        v16 = v;
        a16 = a;
        b16 = b;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog: got no completion, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] rs;
        pv8[0] = 0;  pv8[1] = 0;  pe8[0] = '0;  pe8[1] = '0;
        pv16[0] = 0; pv16[1] = 0; pe16[0] = '0; pe16[1] = '0;
        repeat (3) @(negedge clk);
        // R8: state held in reset
        for (int k = 0; k < 4; k++) begin
            chk("R8", k, 32'(ov8[k]), 32'd0);
            chk("R8", k, 32'(op8[k]), 32'd0);
        end
        for (int k = 0; k < 2; k++) begin
            chk("R8", 10 + k, 32'(ov16[k]), 32'd0);
            chk("R8", 10 + k, op16[k], 32'd0);
        end
        rst_n = 1'b1;
        // R8: idle after release, garbage operands without strobe (R5)
        cyc8(0, 8'h7F, 8'h81, "R8");
        cyc8(0, 8'h55, 8'hAA, "R8");

        // R1 R3 R4 R6 R7: exhaustive narrow sweep with idle gaps
        for (int ai = 0; ai < 256; ai++) begin
            for (int bi = 0; bi < 256; bi++) begin
                cyc8(((ai + bi) % 7) != 3, 8'(ai), 8'(bi), "R1");
            end
        end
        cyc8(0, 8'h00, 8'h00, "R1");
        cyc8(0, 8'h00, 8'h00, "R1");
        cyc8(0, 8'h00, 8'h00, "R5");

        // wide configurations: corners
        cyc16(0, 16'h1234, 16'h5678, "R5");
        cyc16(1, 16'h8000, 16'h8000, "R3");
        cyc16(1, 16'h8000, 16'h0001, "R3");
        cyc16(1, 16'h8000, 16'h7FFF, "R3");
        cyc16(1, 16'h7FFF, 16'h8000, "R3");
        cyc16(1, 16'h7FFF, 16'h7FFF, "R1");
        cyc16(1, 16'h0000, 16'h8000, "R4");
        cyc16(1, 16'hFFFB, 16'h0000, "R4");
        cyc16(1, 16'hFFFF, 16'hFFFF, "R1");
        cyc16(0, 16'hDEAD, 16'hBEEF, "R5");
        cyc16(1, 16'h1200, 16'h0034, "R7");
        cyc16(1, 16'h00F0, 16'h0F00, "R7");
        cyc16(1, 16'hF000, 16'h000F, "R7");
        cyc16(1, 16'hFF01, 16'h0100, "R7");
        rs = 32'h1ACE_B00C;
        for (int n = 0; n < 1000; n++) begin
            logic [15:0] ra, rb;
            rs = rs ^ (rs << 13); rs = rs ^ (rs >> 17); rs = rs ^ (rs << 5);
            ra = rs[15:0];
            rb = rs[31:16];
            if (n % 5 == 1) ra[7:4] = 4'h0;
            if (n % 6 == 2) rb[15:8] = 8'h00;
            cyc16((n % 9) != 4, ra, rb, "R6");
        end
        cyc16(0, 16'h0, 16'h0, "R6");
        cyc16(0, 16'h0, 16'h0, "R6");
        cyc16(0, 16'h0, 16'h0, "R5");

        done = 1'b1;
        summary();
        $finish;
    end
endmodule